// File: doc/BRIEF.md
# Network Interface Interrupt Controller with Deferred Assertion

This block gathers interrupt causes for a network interface and drives a single interrupt line toward the host processor. Device-side logic posts cause bits into a 32-bit status register. Software reads that register, and the read clears it. Software also programs a 32-bit mask. A global enable taken from a configuration register gates the whole line.

The line does not rise as soon as a masked cause appears. A programmable delay, counted in clock cycles, holds it back, so that several events can be coalesced into one interrupt. Causes in an immediate class skip the delay. A delay of zero makes every cause immediate. When a deadline is already running, a later request never pushes it back, but an earlier request replaces it.

Cause encoding: bit 0 receive done, bit 1 receive data done, bit 2 receive FIFO high, bit 3 transmit done, bit 4 transmit data done, bit 5 transmit FIFO low, bits 6 and 7 are urgent causes in the immediate class, and bits 31:8 are reserved.

Top module: `nic_irq_ctrl`

## Requirements
- R1: A post or an explicit clear that touches any reserved bit (31:8) is ignored as a whole: the status keeps its value, and `err_o` is 1 in the cycle after that request and 0 in the cycle after a request without reserved bits.
- R2: A post ORs its bits into the status. If the enable is on and status AND mask is nonzero afterwards, the line rises `delay_cycles` clock edges after the posting edge. If a pending masked cause is in bits 7:6, or `delay_cycles` is 0, the line rises on the posting edge.
- R3: A running deadline that expires no later than a new request is kept. A new request that expires earlier replaces the running deadline.
- R4: `status_o` shows the current status. A read strobe clears all status bits, and an explicit clear drops only the selected bits. A post in the same cycle as a read or clear survives.
- R5: When status AND mask becomes zero, the line drops on that edge and any running deadline is cancelled, so the line stays low after the old deadline passes.
- R6: Writing a mask equal to the current mask changes nothing. Writing a different mask raises the line on that edge if status AND mask is then nonzero, and drops it if it is zero.
- R7: With the enable off, the line stays low and no deadline runs. Switching the enable on while masked causes are pending raises the line on the next edge. Switching it off drops the line on the next edge.
- R8: After reset the status is 0, the line is low, `err_o` is 0 and the mask is 0x00000026 (receive data done, receive FIFO high and transmit FIFO low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global interrupt enable from the configuration register |
| delay_cycles | input | DLY_W | Deferral in clock cycles, 0 means immediate |
| post_valid | input | 1 | Cause post strobe |
| post_bits | input | 32 | Cause bits to post |
| clr_valid | input | 1 | Explicit clear strobe |
| clr_bits | input | 32 | Cause bits to clear |
| rd_status | input | 1 | Status read strobe, clears the status |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | New mask value |
| status_o | output | 32 | Current status register |
| mask_o | output | 32 | Current mask register |
| irq_o | output | 1 | Interrupt line to the host |
| err_o | output | 1 | Reserved-bit request flag |

## Verification
The bench builds the block with its default 16-bit delay width and drives the delay input only with small values between 0 and 10. This keeps deadline expiry, the keep-earlier rule and the replace-by-earlier rule within a few cycles of each post, so each one can be checked at the exact edge where the line must change. Delay 0 and the urgent bits both exercise the immediate path. Enable toggling and mask writes are driven while a deadline is still running, so that cancellation and immediate raising can be told apart.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int unsigned CAUSE_W = 32;
  typedef logic [CAUSE_W-1:0] cause_t;

  // Bits that no source may post or clear
  localparam cause_t RSVD_BITS = 32'hFFFF_FF00;
  // Causes that bypass the deferral counter
  localparam cause_t IMM_BITS  = 32'h0000_00C0;
  // Mask after reset: rx data done, rx FIFO high, tx FIFO low
  localparam cause_t MASK_RST  = 32'h0000_0026;
endpackage

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   post_valid,
  input  cause_t post_bits,
  input  logic   clr_valid,
  input  cause_t clr_bits,
  input  logic   rd_status,
  input  logic   mask_we,
  input  cause_t mask_wdata,
  output cause_t status_q,
  output cause_t mask_q,
  output cause_t masked_nx,
  output logic   post_ok,
  output logic   mask_chg,
  output logic   err_q
);

  logic   post_bad, clr_bad, clr_ok;
  logic   status_en;
  cause_t status_d, mask_d;
  logic   err_d;

  always_comb begin
    post_bad  = post_valid & (|(post_bits & RSVD_BITS));
    clr_bad   = clr_valid  & (|(clr_bits  & RSVD_BITS));
    post_ok   = post_valid & ~post_bad;
    clr_ok    = clr_valid  & ~clr_bad;
    err_d     = post_bad | clr_bad;

    status_d  = status_q;
    if (rd_status) status_d = '0;
    if (clr_ok)    status_d = status_d & ~clr_bits;
    if (post_ok)   status_d = status_d | post_bits;
    status_en = rd_status | clr_ok | post_ok;

    mask_chg  = mask_we & (mask_wdata != mask_q);
    mask_d    = mask_chg ? mask_wdata : mask_q;

    masked_nx = status_d & mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (mask_chg) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/nic_irq_sched.sv
module nic_irq_sched
  import nic_irq_pkg::*;
#(
  parameter int unsigned DLY_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic [DLY_W-1:0] delay_cycles,
  input  cause_t           masked_nx,
  input  logic             post_ok,
  input  logic             mask_chg,
  output logic             irq_q
);

  localparam int unsigned CMP_W = DLY_W + 1;

  logic             en_q, en_d;
  logic             armed_q, armed_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             irq_d;
  logic             any_masked, imm_req, fire_due, later_than_new;
  logic             en_rise;

  always_comb begin
    any_masked     = |masked_nx;
    imm_req        = (|(masked_nx & IMM_BITS)) | (delay_cycles == '0);
    fire_due       = armed_q & (cnt_q == DLY_W'(1));
    en_rise        = glob_en & ~en_q;
    later_than_new = CMP_W'(cnt_q) > (CMP_W'(delay_cycles) + CMP_W'(1));

    en_d    = glob_en;
    irq_d   = irq_q;
    armed_d = armed_q;
    cnt_d   = armed_q ? (cnt_q - DLY_W'(1)) : cnt_q;

    if (fire_due) begin
      armed_d = 1'b0;
      irq_d   = 1'b1;
    end

    if (post_ok && any_masked && glob_en && !irq_q) begin
      if (imm_req) begin
        irq_d   = 1'b1;
        armed_d = 1'b0;
      end else if (!armed_q || later_than_new) begin
        armed_d = 1'b1;
        cnt_d   = delay_cycles;
      end
    end

    if ((mask_chg || en_rise) && any_masked && glob_en) begin
      irq_d   = 1'b1;
      armed_d = 1'b0;
    end

    if (!glob_en || !any_masked) begin
      irq_d   = 1'b0;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
    end
  end

endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
#(
  parameter int unsigned DLY_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic [DLY_W-1:0] delay_cycles,
  input  logic             post_valid,
  input  logic [31:0]      post_bits,
  input  logic             clr_valid,
  input  logic [31:0]      clr_bits,
  input  logic             rd_status,
  input  logic             mask_we,
  input  logic [31:0]      mask_wdata,
  output logic [31:0]      status_o,
  output logic [31:0]      mask_o,
  output logic             irq_o,
  output logic             err_o
);

  cause_t masked_nx;
  logic   post_ok;
  logic   mask_chg;

  nic_irq_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .post_valid (post_valid),
    .post_bits  (post_bits),
    .clr_valid  (clr_valid),
    .clr_bits   (clr_bits),
    .rd_status  (rd_status),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .status_q   (status_o),
    .mask_q     (mask_o),
    .masked_nx  (masked_nx),
    .post_ok    (post_ok),
    .mask_chg   (mask_chg),
    .err_q      (err_o)
  );

  nic_irq_sched #(.DLY_W(DLY_W)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .glob_en      (glob_en),
    .delay_cycles (delay_cycles),
    .masked_nx    (masked_nx),
    .post_ok      (post_ok),
    .mask_chg     (mask_chg),
    .irq_q        (irq_o)
  );

endmodule

// File: rtl/nic_irq_ctrl_chk.sv
module nic_irq_ctrl_chk
  import nic_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        glob_en,
  input logic        post_valid,
  input logic [31:0] post_bits,
  input logic        clr_valid,
  input logic        clr_bits_rsvd,
  input logic        rd_status,
  input logic [31:0] status_o,
  input logic [31:0] mask_o,
  input logic        irq_o,
  input logic        err_o
);

  AST_RSVD_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & RSVD_BITS) == '0); // R1

  AST_ERR_ON_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && ((post_bits & RSVD_BITS) != '0)) |=> err_o); // R1

  AST_RSVD_POST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && ((post_bits & RSVD_BITS) != '0) && !clr_valid && !rd_status)
      |=> $stable(status_o)); // R1

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !post_valid) |=> (status_o == '0)); // R4

  AST_LINE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_o & mask_o) != '0)); // R5

  AST_OFF_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !irq_o); // R7

  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(glob_en)); // R7

  AST_CLR_RSVD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_bits_rsvd) |=> err_o); // R1

endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .glob_en       (glob_en),
  .post_valid    (post_valid),
  .post_bits     (post_bits),
  .clr_valid     (clr_valid),
  .clr_bits_rsvd (|(clr_bits & nic_irq_pkg::RSVD_BITS)),
  .rd_status     (rd_status),
  .status_o      (status_o),
  .mask_o        (mask_o),
  .irq_o         (irq_o),
  .err_o         (err_o)
);

// File: tb/nic_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nic_irq_ctrl_bench;
  localparam int unsigned DLY_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             glob_en = 1'b0;
  logic [DLY_W-1:0] delay_cycles = '0;
  logic             post_valid = 1'b0;
  logic [31:0]      post_bits = '0;
  logic             clr_valid = 1'b0;
  logic [31:0]      clr_bits = '0;
  logic             rd_status = 1'b0;
  logic             mask_we = 1'b0;
  logic [31:0]      mask_wdata = '0;
  logic [31:0]      status_o, mask_o;
  logic             irq_o, err_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nic_irq_ctrl #(.DLY_W(DLY_W)) u_nic_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .delay_cycles(delay_cycles),
    .post_valid(post_valid), .post_bits(post_bits), .clr_valid(clr_valid),
    .clr_bits(clr_bits), .rd_status(rd_status), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .status_o(status_o), .mask_o(mask_o),
    .irq_o(irq_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [7:0] mask;
    logic [7:0] post;
    logic [7:0] st;
    logic       irq_early;
    logic       irq_due;
  } row_t;

  // delay 4, enable on, each row starts from a cleared status
  localparam row_t ROWS [7] = '{
    '{8'h26, 8'h01, 8'h01, 1'b0, 1'b0},
    '{8'h26, 8'h02, 8'h02, 1'b0, 1'b1},
    '{8'hE6, 8'h40, 8'h40, 1'b1, 1'b1},
    '{8'h26, 8'h40, 8'h40, 1'b0, 1'b0},
    '{8'h26, 8'h24, 8'h24, 1'b0, 1'b1},
    '{8'hFF, 8'h80, 8'h80, 1'b1, 1'b1},
    '{8'h00, 8'h3F, 8'h3F, 1'b0, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_post(input logic [31:0] b);
    post_valid = 1'b1; post_bits = b; tick(); post_valid = 1'b0; post_bits = '0;
  endtask

  task automatic do_read();
    rd_status = 1'b1; tick(); rd_status = 1'b0;
  endtask

  task automatic do_mask(input logic [31:0] m);
    mask_we = 1'b1; mask_wdata = m; tick(); mask_we = 1'b0;
  endtask

  task automatic do_clr(input logic [31:0] b);
    clr_valid = 1'b1; clr_bits = b; tick(); clr_valid = 1'b0; clr_bits = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R8 reset state
    chk("R8 status", status_o, 32'h0);
    chk("R8 mask", mask_o, 32'h26);
    chk("R8 irq", {31'b0, irq_o}, 32'h0);
    chk("R8 err", {31'b0, err_o}, 32'h0);

    // R2 table walk
    glob_en = 1'b1;
    delay_cycles = 16'd4;
    tick();
    foreach (ROWS[i]) begin
      do_read();
      do_mask({24'h0, ROWS[i].mask});
      do_post({24'h0, ROWS[i].post});
      chk("R2 status", status_o, {24'h0, ROWS[i].st});
      chk("R2 irq at post", {31'b0, irq_o}, {31'b0, ROWS[i].irq_early});
      tick(); tick(); tick();
      chk("R2 irq before due", {31'b0, irq_o}, {31'b0, ROWS[i].irq_early});
      tick();
      chk("R2 irq at due", {31'b0, irq_o}, {31'b0, ROWS[i].irq_due});
    end
    do_read();
    do_mask(32'h26);

    // R2 zero delay makes any cause immediate
    delay_cycles = 16'd0;
    do_post(32'h2);
    chk("R2 zero delay", {31'b0, irq_o}, 32'h1);
    do_read();
    chk("R5 read drops line", {31'b0, irq_o}, 32'h0);

    // R3 earlier deadline kept
    delay_cycles = 16'd6;
    do_post(32'h2);
    tick();
    delay_cycles = 16'd10;
    do_post(32'h4);
    tick(); tick(); tick();
    chk("R3 kept not yet", {31'b0, irq_o}, 32'h0);
    tick();
    chk("R3 kept fires", {31'b0, irq_o}, 32'h1);
    do_read();

    // R3 earlier request replaces
    delay_cycles = 16'd10;
    do_post(32'h2);
    delay_cycles = 16'd2;
    do_post(32'h4);
    tick();
    chk("R3 replace not yet", {31'b0, irq_o}, 32'h0);
    tick();
    chk("R3 replace fires", {31'b0, irq_o}, 32'h1);
    do_read();

    // R5 cancel on clear
    delay_cycles = 16'd3;
    do_post(32'h2);
    tick();
    do_read();
    repeat (4) tick();
    chk("R5 cancelled", {31'b0, irq_o}, 32'h0);

    // R4 explicit clear, read with simultaneous post
    do_post(32'h3);
    do_clr(32'h2);
    chk("R4 clr selected", status_o, 32'h1);
    rd_status = 1'b1; post_valid = 1'b1; post_bits = 32'h8;
    tick();
    rd_status = 1'b0; post_valid = 1'b0; post_bits = '0;
    chk("R4 post survives read", status_o, 32'h8);
    do_read();
    chk("R4 read clears", status_o, 32'h0);

    // R1 reserved bits
    do_post(32'h0000_0101);
    chk("R1 post err", {31'b0, err_o}, 32'h1);
    chk("R1 post ignored", status_o, 32'h0);
    tick();
    chk("R1 err drops", {31'b0, err_o}, 32'h0);
    do_post(32'h1);
    do_clr(32'h0000_0201);
    chk("R1 clr err", {31'b0, err_o}, 32'h1);
    chk("R1 clr ignored", status_o, 32'h1);
    do_read();

    // R6 mask writes
    delay_cycles = 16'd8;
    do_post(32'h2);
    do_mask(32'h26);
    chk("R6 same mask no raise", {31'b0, irq_o}, 32'h0);
    do_mask(32'h2E);
    chk("R6 new mask raises", {31'b0, irq_o}, 32'h1);
    do_mask(32'h0);
    chk("R6 zero mask drops", {31'b0, irq_o}, 32'h0);
    chk("R6 status kept", status_o, 32'h2);

    // R7 global enable
    glob_en = 1'b0;
    tick();
    do_mask(32'h26);
    chk("R7 off no raise on mask", {31'b0, irq_o}, 32'h0);
    do_read();
    delay_cycles = 16'd2;
    do_post(32'h2);
    tick(); tick(); tick();
    chk("R7 off no deadline", {31'b0, irq_o}, 32'h0);
    glob_en = 1'b1;
    tick();
    chk("R7 on raises", {31'b0, irq_o}, 32'h1);
    glob_en = 1'b0;
    tick();
    chk("R7 off drops", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule